// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Idle Timeout and Break Measurement

This block recovers characters from an asynchronous serial line. An enable pulse, `tick`, arrives at 16 times the bit rate. On each enabled cycle the receiver looks for a falling edge and confirms the start bit at its midpoint. It then samples each following bit at its centre and hands the finished character to the parallel side. The character is a single-cycle `rx_valid` pulse that carries the data word, a parity-error flag and a framing-error flag. The character length runs from 5 to 14 bits. A parity bit is optional, with odd or even sense, and a frame has one or two stop bits.

Once a character has arrived, the receiver counts whole character times in which the line stays high. When that count reaches the programmed limit, it emits a one-cycle `idle_irq` pulse. The host uses this pulse to close its receive buffer. A frame that is low in every position, stop bits included, is treated as a break and not as data. The receiver counts break events. When the line goes high again, it reports how many character times the line was held low.

Top module: `serial_rx_timeout`

## Requirements
- R1: After reset `rx_valid`, `idle_irq` and `brk_done` are low, and `brk_len` and `brk_cnt` are zero.
- R2: A falling edge starts a frame only if the line is still low at the eighth enabled sample after it. Otherwise the edge is dropped and no character is produced.
- R3: Data bits follow the start bit, least significant first. Their count is `cfg_len`, where values below 5 act as 5 and values above 14 act as 14. Bits of `rx_data` above that length are zero, and `rx_valid` is high for exactly one cycle per character.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_odd` = 0 the data and parity bits together hold an even number of ones, and with 1 an odd number. A mismatch sets `rx_perr` with the character. With parity off, `rx_perr` is 0.
- R5: There is one stop bit, or two when `cfg_two_stop` is 1. A low sample at any stop position of a frame that has some high bit sets `rx_ferr` with the character. After that the receiver waits for the line to go high before it accepts a new start.
- R6: Idle counting is armed only by a received character. After reset with no character, no `idle_irq` occurs.
- R7: One idle character is 16 × (1 + length + parity + stop bits) enabled cycles with the line high. After `cfg_idle_max` consecutive idle characters, `idle_irq` pulses once. The counter is then disarmed until the next character.
- R8: Every detected falling edge clears the idle count, even an edge that R2 later rejects.
- R9: `cfg_idle_max` = 0 disables the idle timeout.
- R10: A frame that is low in every position, stop bits included, yields no character and raises `brk_cnt` by one.
- R11: When the line returns high after a break, `brk_done` pulses and `brk_len` gives the number of whole character times the line was low.
- R12: All bit timing advances only on cycles with `tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high, synchronous to clk |
| cfg_len | input | 4 | Data bits per character (5..14, clamped) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_idle_max | input | CNT_W | Idle characters before timeout, 0 disables |
| rx_valid | output | 1 | One-cycle character strobe |
| rx_data | output | 14 | Received character, zero-extended |
| rx_perr | output | 1 | Parity mismatch for this character |
| rx_ferr | output | 1 | Low stop bit for this character |
| idle_irq | output | 1 | One-cycle idle-timeout event |
| brk_done | output | 1 | One-cycle end-of-break strobe |
| brk_len | output | CNT_W | Length of last break in character times |
| brk_cnt | output | CNT_W | Number of breaks received |

## Verification
The bench sends random frames over every length, parity and stop setting, and it injects parity errors. A receiver that mis-ordered the bits or mis-counted the length would return the wrong word. One that skipped or duplicated a bit time would also put the parity or stop checks in the wrong place. The bench sends a short low glitch well into an idle period. A design that did not clear the idle count on that edge would time out early, and one that accepted the glitch as a start would emit a spurious character. The bench also checks the idle pulse from both sides of the expected character count, tests the timeout with no prior character and with a zero limit, and sends breaks of one and three character times. A wrong break counter would show up as a false character or as an off-by-one length.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int MIN_LEN  = 5;
    localparam int MAX_LEN  = 14;
    localparam int OSR      = 16;
    localparam int LEN_W    = 4;
    localparam int MAX_BITS = 1 + MAX_LEN + 1 + 2;
    localparam int TICK_W   = $clog2(OSR * MAX_BITS + 1);
    localparam int POS_W    = $clog2(MAX_BITS + 1);
    localparam int SUB_W    = $clog2(OSR);

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             par_en;
        logic             par_odd;
        logic             two_stop;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_BREAK,
        ST_MARK
    } rx_state_e;

    typedef struct packed {
        logic [MAX_LEN-1:0] data;
        logic               perr;
        logic               ferr;
    } rx_char_t;

    // Character length after clamping to the legal range.
    function automatic logic [LEN_W-1:0] eff_len(input frame_cfg_t c);
        if (c.len < LEN_W'(MIN_LEN))
            return LEN_W'(MIN_LEN);
        else if (c.len > LEN_W'(MAX_LEN))
            return LEN_W'(MAX_LEN);
        else
            return c.len;
    endfunction

    // Number of bit slots that follow the start bit.
    function automatic logic [POS_W-1:0] tail_bits(input frame_cfg_t c);
        return POS_W'(eff_len(c)) + POS_W'(c.par_en) +
               (c.two_stop ? POS_W'(2) : POS_W'(1));
    endfunction

    // One whole character time in enabled samples.
    function automatic logic [TICK_W-1:0] char_ticks(input frame_cfg_t c);
        return TICK_W'(OSR) * (TICK_W'(tail_bits(c)) + TICK_W'(1));
    endfunction

endpackage

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  frame_cfg_t cfg,
    output logic       in_idle,
    output logic       in_break,
    output logic       start_seen,
    output logic       char_done,
    output rx_char_t   char_out,
    output logic       brk_begin,
    output logic       brk_end
);

    localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(OSR / 2 - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);

    rx_state_e          state;
    logic [SUB_W-1:0]   sub;
    logic [POS_W-1:0]   pos;
    logic [MAX_LEN-1:0] shreg;
    logic               par_bit;
    logic               stop_low;
    logic               seen_high;

    logic [LEN_W-1:0]   len_e;
    logic [POS_W-1:0]   nbits;
    logic               is_data;
    logic               is_par;
    logic               is_stop;
    logic               last_pos;
    logic               par_bad;

    always_comb begin
        len_e    = eff_len(cfg);
        nbits    = tail_bits(cfg);
        is_data  = pos < POS_W'(len_e);
        is_par   = cfg.par_en && (pos == POS_W'(len_e));
        is_stop  = pos >= (POS_W'(len_e) + POS_W'(cfg.par_en));
        last_pos = pos == (nbits - POS_W'(1));
        par_bad  = cfg.par_en && ((^shreg ^ par_bit) != cfg.par_odd);
        in_idle  = state == ST_IDLE;
        in_break = state == ST_BREAK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            sub        <= '0;
            pos        <= '0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            stop_low   <= 1'b0;
            seen_high  <= 1'b0;
            start_seen <= 1'b0;
            char_done  <= 1'b0;
            char_out   <= '0;
            brk_begin  <= 1'b0;
            brk_end    <= 1'b0;
        end else begin
            start_seen <= 1'b0;
            char_done  <= 1'b0;
            brk_begin  <= 1'b0;
            brk_end    <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!rxd) begin
                            state      <= ST_START;
                            sub        <= '0;
                            start_seen <= 1'b1;
                        end
                    end
                    ST_START: begin
                        if (sub == SUB_HALF) begin
                            if (rxd) begin
                                state <= ST_IDLE;
                            end else begin
                                state     <= ST_BITS;
                                sub       <= '0;
                                pos       <= '0;
                                shreg     <= '0;
                                par_bit   <= 1'b0;
                                stop_low  <= 1'b0;
                                seen_high <= 1'b0;
                            end
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    ST_BITS: begin
                        if (sub == SUB_LAST) begin
                            sub <= '0;
                            pos <= pos + 1'b1;
                            for (int i = 0; i < MAX_LEN; i++) begin
                                if (is_data && (pos == POS_W'(i)))
                                    shreg[i] <= rxd;
                            end
                            if (is_par)
                                par_bit <= rxd;
                            if (is_stop && !rxd)
                                stop_low <= 1'b1;
                            if (rxd)
                                seen_high <= 1'b1;
                            if (last_pos) begin
                                if (!seen_high && !rxd) begin
                                    state     <= ST_BREAK;
                                    brk_begin <= 1'b1;
                                end else begin
                                    char_done     <= 1'b1;
                                    char_out.data <= shreg;
                                    char_out.perr <= par_bad;
                                    char_out.ferr <= stop_low | !rxd;
                                    state <= (stop_low | !rxd) ? ST_MARK : ST_IDLE;
                                end
                            end
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    ST_BREAK: begin
                        if (rxd) begin
                            state   <= ST_IDLE;
                            brk_end <= 1'b1;
                        end
                    end
                    ST_MARK: begin
                        if (rxd)
                            state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/srx_idle.sv
module srx_idle
    import srx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              in_idle,
    input  logic              start_seen,
    input  logic              char_done,
    input  logic [TICK_W-1:0] char_len_ticks,
    input  logic [CNT_W-1:0]  idle_max,
    output logic              idle_irq
);

    logic              armed;
    logic [TICK_W-1:0] tcnt;
    logic [CNT_W-1:0]  chars;
    logic              char_wrap;
    logic              limit_hit;

    always_comb begin
        char_wrap = tcnt == (char_len_ticks - TICK_W'(1));
        limit_hit = (chars + 1'b1) == idle_max;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            tcnt     <= '0;
            chars    <= '0;
            idle_irq <= 1'b0;
        end else begin
            idle_irq <= 1'b0;
            if (char_done) begin
                armed <= 1'b1;
                tcnt  <= '0;
                chars <= '0;
            end else if (start_seen) begin
                tcnt  <= '0;
                chars <= '0;
            end else if (tick && armed && in_idle && (idle_max != '0)) begin
                if (char_wrap) begin
                    tcnt <= '0;
                    if (limit_hit) begin
                        idle_irq <= 1'b1;
                        armed    <= 1'b0;
                        chars    <= '0;
                    end else begin
                        chars <= chars + 1'b1;
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/srx_break.sv
module srx_break
    import srx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              in_break,
    input  logic              brk_begin,
    input  logic              brk_end,
    input  logic [TICK_W-1:0] char_len_ticks,
    output logic [CNT_W-1:0]  brk_len,
    output logic [CNT_W-1:0]  brk_cnt,
    output logic              brk_done
);

    logic [TICK_W-1:0] tcnt;
    logic [CNT_W-1:0]  run;

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt     <= '0;
            run      <= '0;
            brk_len  <= '0;
            brk_cnt  <= '0;
            brk_done <= 1'b0;
        end else begin
            brk_done <= 1'b0;
            if (brk_begin) begin
                run  <= CNT_W'(1);
                tcnt <= '0;
                if (brk_cnt != '1)
                    brk_cnt <= brk_cnt + 1'b1;
            end else if (brk_end) begin
                brk_len  <= run;
                brk_done <= 1'b1;
            end else if (tick && in_break) begin
                if (tcnt == (char_len_ticks - TICK_W'(1))) begin
                    tcnt <= '0;
                    if (run != '1)
                        run <= run + 1'b1;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/serial_rx_timeout.sv
module serial_rx_timeout
    import srx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               rxd,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic               cfg_par_en,
    input  logic               cfg_par_odd,
    input  logic               cfg_two_stop,
    input  logic [CNT_W-1:0]   cfg_idle_max,
    output logic               rx_valid,
    output logic [MAX_LEN-1:0] rx_data,
    output logic               rx_perr,
    output logic               rx_ferr,
    output logic               idle_irq,
    output logic               brk_done,
    output logic [CNT_W-1:0]   brk_len,
    output logic [CNT_W-1:0]   brk_cnt
);

    frame_cfg_t        cfg;
    logic [TICK_W-1:0] frame_ticks;
    rx_char_t          ch;
    logic              in_idle;
    logic              in_break;
    logic              start_seen;
    logic              brk_begin;
    logic              brk_end;

    always_comb begin
        cfg.len      = cfg_len;
        cfg.par_en   = cfg_par_en;
        cfg.par_odd  = cfg_par_odd;
        cfg.two_stop = cfg_two_stop;
        frame_ticks  = char_ticks(cfg);
    end

    srx_frame u_frame (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .rxd        (rxd),
        .cfg        (cfg),
        .in_idle    (in_idle),
        .in_break   (in_break),
        .start_seen (start_seen),
        .char_done  (rx_valid),
        .char_out   (ch),
        .brk_begin  (brk_begin),
        .brk_end    (brk_end)
    );

    srx_idle #(.CNT_W(CNT_W)) u_idle (
        .clk            (clk),
        .rst            (rst),
        .tick           (tick),
        .in_idle        (in_idle),
        .start_seen     (start_seen),
        .char_done      (rx_valid),
        .char_len_ticks (frame_ticks),
        .idle_max       (cfg_idle_max),
        .idle_irq       (idle_irq)
    );

    srx_break #(.CNT_W(CNT_W)) u_break (
        .clk            (clk),
        .rst            (rst),
        .tick           (tick),
        .in_break       (in_break),
        .brk_begin      (brk_begin),
        .brk_end        (brk_end),
        .char_len_ticks (frame_ticks),
        .brk_len        (brk_len),
        .brk_cnt        (brk_cnt),
        .brk_done       (brk_done)
    );

    always_comb begin
        rx_data = ch.data;
        rx_perr = ch.perr;
        rx_ferr = ch.ferr;
    end

endmodule

// File: rtl/srx_checker.sv
module srx_checker
    import srx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [LEN_W-1:0]   cfg_len,
    input logic               cfg_par_en,
    input logic [CNT_W-1:0]   cfg_idle_max,
    input logic               rx_valid,
    input logic [MAX_LEN-1:0] rx_data,
    input logic               rx_perr,
    input logic               idle_irq,
    input logic               brk_done,
    input logic [CNT_W-1:0]   brk_len,
    input logic [CNT_W-1:0]   brk_cnt
);

    logic [3:0] chk_len;
    always_comb begin
        if (cfg_len < 4'd5)
            chk_len = 4'd5;
        else if (cfg_len > 4'd14)
            chk_len = 4'd14;
        else
            chk_len = cfg_len;
    end

    a_r3_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> ((rx_data >> chk_len) == '0));

    a_r4_no_perr_without_parity: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !cfg_par_en) |-> !rx_perr);

    a_r7_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        idle_irq |=> !idle_irq);

    a_r9_idle_off: assert property (@(posedge clk) disable iff (rst)
        (cfg_idle_max == '0) |-> !idle_irq);

    a_r10_cnt_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(brk_cnt) |-> (brk_cnt == $past(brk_cnt) + 1'b1));

    a_r10_break_not_char: assert property (@(posedge clk) disable iff (rst)
        brk_done |-> !rx_valid);

    a_r11_len_nonzero: assert property (@(posedge clk) disable iff (rst)
        brk_done |-> (brk_len != '0));

endmodule

bind serial_rx_timeout srx_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/serial_rx_timeout_tb.sv
module serial_rx_timeout_tb;
    import srx_pkg::*;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick;
    logic             rxd = 1'b1;
    logic [3:0]       cfg_len = 4'd8;
    logic             cfg_par_en = 1'b0;
    logic             cfg_par_odd = 1'b0;
    logic             cfg_two_stop = 1'b0;
    logic [CNT_W-1:0] cfg_idle_max = '0;
    logic             rx_valid;
    logic [13:0]      rx_data;
    logic             rx_perr;
    logic             rx_ferr;
    logic             idle_irq;
    logic             brk_done;
    logic [CNT_W-1:0] brk_len;
    logic [CNT_W-1:0] brk_cnt;

    int checks = 0;
    int errors = 0;
    int tdiv   = 1;
    int tphase = 0;
    bit finished = 0;

    int          n_valid = 0;
    int          n_irq   = 0;
    int          n_brk   = 0;
    logic [13:0] last_data = '0;
    logic        last_perr = 1'b0;
    logic        last_ferr = 1'b0;
    logic [15:0] last_blen = '0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (tphase >= tdiv - 1) tphase <= 0;
        else tphase <= tphase + 1;
    end
    assign tick = (tphase == 0);

    serial_rx_timeout #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_idle_max(cfg_idle_max),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .idle_irq(idle_irq), .brk_done(brk_done), .brk_len(brk_len), .brk_cnt(brk_cnt)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                n_valid   = n_valid + 1;
                last_data = rx_data;
                last_perr = rx_perr;
                last_ferr = rx_ferr;
            end
            if (idle_irq) n_irq = n_irq + 1;
            if (brk_done) begin
                n_brk     = n_brk + 1;
                last_blen = brk_len;
            end
        end
    end

    function automatic int clamp_len(input int l);
        if (l < 5) return 5;
        if (l > 14) return 14;
        return l;
    endfunction

    function automatic int frame_cycles(input int l, input bit pe, input bit ts);
        return 16 * tdiv * (1 + clamp_len(l) + int'(pe) + (ts ? 2 : 1));
    endfunction

    function automatic logic [13:0] mask_data(input logic [13:0] d, input int l);
        logic [13:0] m;
        m = 14'((32'd1 << l) - 1);
        return d & m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rxd <= b;
        repeat (16 * tdiv) @(posedge clk);
    endtask

    task automatic send_frame(input logic [13:0] d, input int l, input bit pe, input bit po,
                              input bit ts, input bit bad_p, input bit bad_s);
        logic [13:0] dm;
        dm = mask_data(d, l);
        send_bit(1'b0);
        for (int i = 0; i < l; i++) send_bit(dm[i]);
        if (pe) send_bit((^dm) ^ po ^ bad_p);
        send_bit(!bad_s);
        if (ts) send_bit(!bad_s);
        rxd <= 1'b1;
    endtask

    task automatic gap();
        send_bit(1'b1);
        send_bit(1'b1);
    endtask

    task automatic set_cfg(input int l, input bit pe, input bit po, input bit ts);
        cfg_len      <= 4'(l);
        cfg_par_en   <= pe;
        cfg_par_odd  <= po;
        cfg_two_stop <= ts;
        @(posedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        int f8;
        int v0;
        int b0;
        seed_v = $urandom(32'd2024);
        repeat (5) @(posedge clk);
        rst <= 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 valid", 32'(rx_valid), 0);
        check("R1 irq", 32'(idle_irq), 0);
        check("R1 brk_done", 32'(brk_done), 0);
        check("R1 brk_len", 32'(brk_len), 0);
        check("R1 brk_cnt", 32'(brk_cnt), 0);

        // R6: no character yet, idle limit set, no timeout
        cfg_idle_max <= 16'd2;
        set_cfg(8, 0, 0, 0);
        f8 = frame_cycles(8, 0, 0);
        repeat (5 * f8) @(posedge clk);
        check("R6 no irq before any char", 32'(n_irq), 0);

        // R3/R4/R5 random frames
        for (int k = 0; k < 30; k++) begin
            int l;
            bit pe, po, ts, bp;
            logic [13:0] d;
            l  = 5 + int'($urandom % 10);
            pe = 1'($urandom % 2);
            po = 1'($urandom % 2);
            ts = 1'($urandom % 2);
            bp = pe && (($urandom % 4) == 0);
            d  = 14'($urandom);
            set_cfg(l, pe, po, ts);
            v0 = n_valid;
            send_frame(d, l, pe, po, ts, bp, 0);
            gap();
            check("R3 random char count", 32'(n_valid), 32'(v0 + 1));
            check("R3 random data", 32'(last_data), 32'(mask_data(d, l)));
            check("R4 random parity flag", 32'(last_perr), 32'(bp));
            check("R5 random no ferr", 32'(last_ferr), 0);
        end

        // R3 length clamp above 14
        set_cfg(15, 0, 0, 0);
        send_frame(14'h2ABC, 14, 0, 0, 0, 0, 0);
        gap();
        check("R3 clamp high data", 32'(last_data), 32'h2ABC);
        // R3 length clamp below 5
        set_cfg(2, 1, 1, 0);
        send_frame(14'h0013, 5, 1, 1, 0, 0, 0);
        gap();
        check("R3 clamp low data", 32'(last_data), 32'h13);
        check("R4 clamp low odd parity ok", 32'(last_perr), 0);

        // R5 framing error, two stop bits
        set_cfg(8, 0, 0, 1);
        v0 = n_valid;
        send_frame(14'h05A, 8, 0, 0, 1, 0, 1);
        gap();
        check("R5 ferr char count", 32'(n_valid), 32'(v0 + 1));
        check("R5 ferr flag", 32'(last_ferr), 1);
        check("R5 ferr data", 32'(last_data), 32'h5A);
        send_frame(14'h0C3, 8, 0, 0, 1, 0, 0);
        gap();
        check("R5 recovery data", 32'(last_data), 32'hC3);
        check("R5 recovery no ferr", 32'(last_ferr), 0);

        // R12 slower tick
        tdiv = 2;
        set_cfg(10, 1, 0, 0);
        send_frame(14'h2D5, 10, 1, 0, 0, 0, 0);
        gap();
        check("R12 half-rate tick data", 32'(last_data), 32'h2D5);
        check("R12 half-rate tick perr", 32'(last_perr), 0);
        tdiv = 1;
        repeat (4) @(posedge clk);

        // R7 idle timeout with limit 3
        set_cfg(8, 0, 0, 0);
        cfg_idle_max <= 16'd3;
        f8 = frame_cycles(8, 0, 0);
        send_frame(14'h0A5, 8, 0, 0, 0, 0, 0);
        b0 = n_irq;
        repeat (3 * f8 - 40) @(posedge clk);
        check("R7 no irq before limit", 32'(n_irq), 32'(b0));
        repeat (80) @(posedge clk);
        check("R7 irq at limit", 32'(n_irq), 32'(b0 + 1));
        repeat (4 * f8) @(posedge clk);
        check("R7 disarmed after irq", 32'(n_irq), 32'(b0 + 1));

        // R8 + R2: glitch restarts idle count, yields no char
        send_frame(14'h033, 8, 0, 0, 0, 0, 0);
        b0 = n_irq;
        v0 = n_valid;
        repeat (2 * f8) @(posedge clk);
        rxd <= 1'b0;
        repeat (3) @(posedge clk);
        rxd <= 1'b1;
        repeat (2 * f8 + f8 / 2) @(posedge clk);
        check("R8 glitch cleared idle count", 32'(n_irq), 32'(b0));
        check("R2 glitch gives no char", 32'(n_valid), 32'(v0));
        repeat (f8 / 2 + 40) @(posedge clk);
        check("R8 irq after restart", 32'(n_irq), 32'(b0 + 1));

        // R9 limit zero disables
        cfg_idle_max <= '0;
        send_frame(14'h0F0, 8, 0, 0, 0, 0, 0);
        b0 = n_irq;
        repeat (6 * f8) @(posedge clk);
        check("R9 no irq when disabled", 32'(n_irq), 32'(b0));

        // R10/R11 break of one character time
        v0 = n_valid;
        b0 = n_brk;
        rxd <= 1'b0;
        repeat (f8) @(posedge clk);
        rxd <= 1'b1;
        gap();
        check("R10 break no char", 32'(n_valid), 32'(v0));
        check("R10 break count 1", 32'(brk_cnt), 1);
        check("R11 break done 1", 32'(n_brk), 32'(b0 + 1));
        check("R11 break length 1", 32'(last_blen), 1);

        // R10/R11 break of three character times, parity and two stops
        set_cfg(6, 1, 1, 1);
        rxd <= 1'b0;
        repeat (3 * frame_cycles(6, 1, 1)) @(posedge clk);
        rxd <= 1'b1;
        gap();
        check("R10 break no char 2", 32'(n_valid), 32'(v0));
        check("R10 break count 2", 32'(brk_cnt), 2);
        check("R11 break length 3", 32'(last_blen), 3);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule